// File: doc/BRIEF.md
# Integer Add/Subtract Execute Unit

This block takes at most one 32-bit instruction word per clock, qualified by a valid strobe, and executes the three integer add forms of the base instruction set against a private bank of thirty-two 32-bit registers. The three forms are register plus register, register minus register, and register plus a sign-extended 12-bit constant. It reads its two sources combinationally. It forms a wrapping sum or difference and writes the destination register at the next rising edge.

Any word outside those three encodings raises an illegal flag for the cycle it is presented and changes no register. Register zero is hardwired to zero. Arithmetic overflow is dropped silently. A combinational debug port lets a test environment read any register at any time.

Top module: `iadd_exec_unit`

## Requirements
- R1: With opcode (bits 6..0) 0110011, funct3 (bits 14..12) 000 and funct7 (bits 31..25) 0000000, the unit writes rs1+rs2 into rd. The source fields are rs1 in bits 19..15 and rs2 in bits 24..20, and the destination field rd is in bits 11..7.
- R2: With the same opcode and funct3 and funct7 0100000 (instruction bit 30 set), the unit writes rs1-rs2 into rd.
- R3: With opcode 0010011 and funct3 000, the unit writes rs1 plus bits 31..20 sign-extended into rd. The constant ranges from -2048 to 2047.
- R4: Results keep only the low 32 bits. 0x7FFFFFFF+1 gives 0x80000000, and 0-1 gives 0xFFFFFFFF. Overflow never raises the illegal flag.
- R5: Register 0 always reads as zero, and an instruction with rd = 0 leaves it zero.
- R6: Any other opcode, funct3 or funct7 value raises `illegal` in the same cycle and writes no register.
- R7: A write lands on the rising edge only while `instr_valid` is high. An instruction in the next cycle sees the new value. An instruction that reads and writes the same register uses the old value. With `instr_valid` low, no register changes and `illegal` stays low.
- R8: A synchronous active-high `rst` clears all registers to zero.
- R9: `dbg_data` combinationally shows the register selected by `dbg_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word present this cycle |
| instr_word | input | 32 | Instruction word |
| illegal | output | 1 | Presented word is not a supported encoding |
| dbg_sel | input | 5 | Register index for the debug read |
| dbg_data | output | 32 | Contents of the selected register |

## Verification
Two things can fall in the same cycle: a register read and a register write. An instruction may name the same register as source and destination, and the debug port may watch a register while it is being written. The bench provokes this with doubling chains such as rd = rd + rd and with back-to-back dependent instructions. It judges the result by reading rd after each edge and comparing it with a model that reads its sources before it updates. Random streams that reuse few registers raise how often these collisions occur.

// File: rtl/iadd_pkg.sv
package iadd_pkg;

    localparam int unsigned ILEN      = 32;
    localparam int unsigned IMM_W     = 12;
    localparam int unsigned REG_IDX_W = 5;

    localparam logic [6:0] OPC_REGREG = 7'b0110011;
    localparam logic [6:0] OPC_REGIMM = 7'b0010011;
    localparam logic [2:0] F3_ADDSUB  = 3'b000;
    localparam logic [6:0] F7_PLAIN   = 7'b0000000;
    localparam logic [6:0] F7_NEGATE  = 7'b0100000;

    typedef enum logic [1:0] {
        KIND_NONE = 2'd0,
        KIND_RR   = 2'd1,
        KIND_RI   = 2'd2
    } instr_kind_e;

    typedef struct packed {
        logic [6:0]           funct7;
        logic [REG_IDX_W-1:0] src2;
        logic [REG_IDX_W-1:0] src1;
        logic [2:0]           funct3;
        logic [REG_IDX_W-1:0] dest;
        logic [6:0]           opcode;
    } rr_fields_t;

    typedef struct packed {
        instr_kind_e          kind;
        logic                 negate;
        logic [REG_IDX_W-1:0] dest;
        logic [REG_IDX_W-1:0] src1;
        logic [REG_IDX_W-1:0] src2;
        logic [IMM_W-1:0]     imm;
    } uop_t;

    function automatic uop_t crack(input logic [ILEN-1:0] word);
        rr_fields_t f;
        uop_t       u;
        f        = rr_fields_t'(word);
        u.kind   = KIND_NONE;
        u.negate = 1'b0;
        u.dest   = f.dest;
        u.src1   = f.src1;
        u.src2   = f.src2;
        u.imm    = word[31:20];
        if (f.opcode == OPC_REGREG && f.funct3 == F3_ADDSUB) begin
            if (f.funct7 == F7_PLAIN || f.funct7 == F7_NEGATE) begin
                u.kind   = KIND_RR;
                u.negate = word[30];
            end
        end else if (f.opcode == OPC_REGIMM && f.funct3 == F3_ADDSUB) begin
            u.kind = KIND_RI;
        end
        return u;
    endfunction

endpackage

// File: rtl/iadd_decode.sv
module iadd_decode
    import iadd_pkg::*;
(
    input  logic            valid,
    input  logic [ILEN-1:0] word,
    output uop_t            uop,
    output logic            accept,
    output logic            reject
);
    uop_t cracked;

    always_comb begin
        cracked = crack(word);
        uop     = cracked;
        accept  = valid && (cracked.kind != KIND_NONE);
        reject  = valid && (cracked.kind == KIND_NONE);
    end
endmodule

// File: rtl/iadd_regfile.sv
module iadd_regfile #(
    parameter int unsigned XLEN  = 32,
    parameter int unsigned NREG  = 32,
    localparam int unsigned IDXW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [IDXW-1:0] waddr,
    input  logic [XLEN-1:0] wdata,
    input  logic [IDXW-1:0] raddr_a,
    input  logic [IDXW-1:0] raddr_b,
    input  logic [IDXW-1:0] raddr_d,
    output logic [XLEN-1:0] rdata_a,
    output logic [XLEN-1:0] rdata_b,
    output logic [XLEN-1:0] rdata_d
);
    logic [XLEN-1:0] entry [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_entry
        if (i == 0) begin : g_zero
            assign entry[i] = '0;
        end else begin : g_flop
            logic [XLEN-1:0] q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= '0;
                end else if (we && waddr == IDXW'(i)) begin
                    q <= wdata;
                end
            end
            assign entry[i] = q;
        end
    end

    assign rdata_a = entry[raddr_a];
    assign rdata_b = entry[raddr_b];
    assign rdata_d = entry[raddr_d];
endmodule

// File: rtl/iadd_alu.sv
module iadd_alu #(
    parameter int unsigned XLEN = 32
) (
    input  logic [XLEN-1:0] lhs,
    input  logic [XLEN-1:0] rhs,
    input  logic            negate,
    output logic [XLEN-1:0] sum
);
    logic [XLEN-1:0] rhs_x;

    always_comb begin
        rhs_x = rhs ^ {XLEN{negate}};
        sum   = lhs + rhs_x + XLEN'(negate);
    end
endmodule

// File: rtl/iadd_exec_unit.sv
module iadd_exec_unit
    import iadd_pkg::*;
#(
    parameter int unsigned XLEN = 32,
    parameter int unsigned NREG = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 instr_valid,
    input  logic [ILEN-1:0]      instr_word,
    output logic                 illegal,
    input  logic [REG_IDX_W-1:0] dbg_sel,
    output logic [XLEN-1:0]      dbg_data
);
    uop_t            uop;
    logic            accept;
    logic [XLEN-1:0] opnd_a;
    logic [XLEN-1:0] opnd_b_reg;
    logic [XLEN-1:0] opnd_b;
    logic [XLEN-1:0] imm_ext;
    logic [XLEN-1:0] result;
    logic            do_negate;

    iadd_decode u_dec (
        .valid  (instr_valid),
        .word   (instr_word),
        .uop    (uop),
        .accept (accept),
        .reject (illegal)
    );

    iadd_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .we      (accept),
        .waddr   (uop.dest),
        .wdata   (result),
        .raddr_a (uop.src1),
        .raddr_b (uop.src2),
        .raddr_d (dbg_sel),
        .rdata_a (opnd_a),
        .rdata_b (opnd_b_reg),
        .rdata_d (dbg_data)
    );

    always_comb begin
        imm_ext   = {{(XLEN-IMM_W){uop.imm[IMM_W-1]}}, uop.imm};
        opnd_b    = (uop.kind == KIND_RI) ? imm_ext : opnd_b_reg;
        do_negate = (uop.kind == KIND_RR) && uop.negate;
    end

    iadd_alu #(.XLEN(XLEN)) u_alu (
        .lhs    (opnd_a),
        .rhs    (opnd_b),
        .negate (do_negate),
        .sum    (result)
    );
endmodule

// File: rtl/iadd_exec_unit_chk.sv
module iadd_exec_unit_chk #(
    parameter int unsigned XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            instr_valid,
    input logic            illegal,
    input logic            wr_en,
    input logic            is_sub,
    input logic [XLEN-1:0] opa,
    input logic [XLEN-1:0] opb,
    input logic [XLEN-1:0] wr_data,
    input logic [4:0]      dbg_sel,
    input logic [XLEN-1:0] dbg_data
);
    // R6
    illegal_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        illegal |-> !wr_en);

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !instr_valid |-> (!illegal && !wr_en));

    // R5
    zero_reg_chk: assert property (@(posedge clk) disable iff (rst)
        (dbg_sel == 5'd0) |-> (dbg_data == '0));

    // R2
    sub_inverse_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && is_sub) |-> ((wr_data + opb) == opa));

    // R8
    reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (dbg_data == '0));
endmodule

bind iadd_exec_unit iadd_exec_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .instr_valid (instr_valid),
    .illegal     (illegal),
    .wr_en       (accept),
    .is_sub      (do_negate),
    .opa         (opnd_a),
    .opb         (opnd_b),
    .wr_data     (result),
    .dbg_sel     (dbg_sel),
    .dbg_data    (dbg_data)
);

// File: tb/iadd_exec_unit_tb_top.sv
`timescale 1ns/1ps
module iadd_exec_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_valid = 1'b0;
    logic [31:0] instr_word = 32'h0;
    logic        illegal;
    logic [4:0]  dbg_sel = 5'd0;
    logic [31:0] dbg_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [31:0] model [32];

    always #4 clk = ~clk;

    iadd_exec_unit dut_i (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
        .illegal(illegal), .dbg_sel(dbg_sel), .dbg_data(dbg_data)
    );

    function automatic logic [31:0] enc_rr(input bit sub, input int rd, input int a, input int b);
        return {1'b0, sub, 5'b0, 5'(b), 5'(a), 3'b000, 5'(rd), 7'b0110011};
    endfunction

    function automatic logic [31:0] enc_ri(input int rd, input int a, input logic [11:0] imm);
        return {imm, 5'(a), 3'b000, 5'(rd), 7'b0010011};
    endfunction

    function automatic bit supported(input logic [31:0] w);
        if (w[6:0] == 7'h33 && w[14:12] == 3'd0 && (w[31:25] == 7'h00 || w[31:25] == 7'h20)) return 1'b1;
        if (w[6:0] == 7'h13 && w[14:12] == 3'd0) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [31:0] predict(input logic [31:0] w);
        logic [31:0] a;
        logic [31:0] b;
        a = model[w[19:15]];
        b = model[w[24:20]];
        if (w[6:0] == 7'h13) return a + {{20{w[31]}}, w[31:20]};
        if (w[30]) return a - b;
        return a + b;
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic run(input logic [31:0] w, input string req);
        logic [31:0] expv;
        bit ok;
        @(negedge clk);
        instr_valid = 1'b1;
        instr_word = w;
        #1;
        ok = supported(w);
        check({req, " illegal flag"}, {31'b0, illegal}, {31'b0, !ok});
        expv = predict(w);
        @(posedge clk);
        #1;
        if (ok && w[11:7] != 5'd0) model[w[11:7]] = expv;
        dbg_sel = w[11:7];
        #1;
        check({req, " dest value"}, dbg_data, model[w[11:7]]);
    endtask

    task automatic idle();
        @(negedge clk);
        instr_valid = 1'b0;
    endtask

    task automatic scan_all(input string req);
        for (int i = 0; i < 32; i++) begin
            dbg_sel = 5'(i);
            #1;
            check(req, dbg_data, model[i]);
        end
    endtask

    initial begin
        #(8 * 190000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog got=hung exp=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] w;
        void'($urandom(32'd1234));
        for (int i = 0; i < 32; i++) model[i] = 32'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R8 R9: reset state
        scan_all("R8 reset clear");

        // R3 immediate forms, including -2048
        run(enc_ri(1, 0, 12'h7FF), "R3 imm max");
        run(enc_ri(2, 0, 12'h800), "R3 imm -2048");
        run(enc_ri(3, 1, 12'h001), "R3 imm +1");
        // R1 add, R2 subtract
        run(enc_rr(0, 4, 1, 3), "R1 add");
        run(enc_rr(1, 5, 1, 2), "R2 sub");
        // R7 same register read and written; back-to-back dependency
        run(enc_ri(6, 0, 12'h001), "R7 seed");
        for (int i = 0; i < 31; i++) run(enc_rr(0, 6, 6, 6), "R7 doubling");
        check("R7 doubling end", model[6], 32'h80000000);
        // R4 wraparound
        run(enc_ri(7, 6, 12'hFFF), "R4 build max");
        run(enc_ri(8, 0, 12'h001), "R4 one");
        run(enc_rr(0, 9, 7, 8), "R4 max plus one");
        check("R4 wrap value", dbg_data, 32'h80000000);
        run(enc_rr(1, 10, 0, 8), "R4 zero minus one");
        check("R4 borrow value", dbg_data, 32'hFFFFFFFF);
        run(enc_rr(0, 11, 10, 10), "R4 overflow add");
        // R5 writes aimed at x0
        run(enc_ri(0, 1, 12'h123), "R5 imm to x0");
        run(enc_rr(0, 0, 7, 7), "R5 add to x0");
        run(enc_rr(1, 0, 0, 8), "R5 sub to x0");
        run(enc_rr(0, 12, 0, 0), "R5 x0 operands");
        // R6 illegal encodings
        run(32'h4000_80B3 | 32'h0000_1000, "R6 bad funct3");
        run({7'b0000001, 5'd1, 5'd2, 3'b000, 5'd3, 7'b0110011}, "R6 bad funct7");
        run({7'b0100000, 5'd1, 5'd2, 3'b000, 5'd3, 7'b0010111}, "R6 bad opcode");
        run({12'h005, 5'd1, 3'b010, 5'd3, 7'b0010011}, "R6 imm bad funct3");
        idle();
        scan_all("R6 no state change");
        // R7 valid low: word ignored
        @(negedge clk);
        instr_valid = 1'b0;
        instr_word = enc_ri(1, 0, 12'h055);
        #1;
        check("R7 idle illegal low", {31'b0, illegal}, 32'h0);
        @(posedge clk);
        #1;
        scan_all("R7 idle no write");

        // random mix
        for (int n = 0; n < 600; n++) begin
            int k;
            k = int'($urandom_range(0, 9));
            if (k < 3) w = enc_rr(0, int'($urandom_range(0, 7)), int'($urandom_range(0, 7)), int'($urandom_range(0, 7)));
            else if (k < 6) w = enc_rr(1, int'($urandom_range(0, 7)), int'($urandom_range(0, 7)), int'($urandom_range(0, 7)));
            else if (k < 9) w = enc_ri(int'($urandom_range(0, 7)), int'($urandom_range(0, 7)), 12'($urandom));
            else w = $urandom;
            run(w, "R1 R2 R3 R6 random");
        end
        idle();
        scan_all("R9 final scan");

        // R8 reset clears loaded registers
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 32; i++) model[i] = 32'h0;
        scan_all("R8 clear after use");

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule